// File: doc/BRIEF.md
# Reversible Function Class Canonicalizer

This block reduces a 3-variable reversible function to one fixed member of its cost-equivalence class. The function arrives as eight 3-bit outputs, one per input assignment. Two functions share a class when one becomes the other by renaming the variables on the input side and the output side together, optionally after inverting the function. Such a class holds at most twelve members. The representative is the member whose vector is smallest when the vectors are compared as words, entry 0 first.

A request is accepted with `start` while the block is idle. The block first checks that the eight outputs are all distinct. If they are not, it reports an error at once. Otherwise it visits the twelve candidates, one per clock, and keeps the smallest. When it finishes, it reports the winning vector together with the bit permutation and the inversion flag that produced it. A caller can use the result as a key into a table of precomputed circuits.

Top module: `revCanon`

## Requirements
- R1: After reset, `busy`, `done` and `notPerm` are low, and `canonOut`, `permIdx` and `invFlag` are zero.
- R2: A `start` sampled high while `busy` is low is accepted, and `busy` is high from the next cycle until the cycle in which `done` rises. A `start` sampled while `busy` is high is ignored and has no effect on the result.
- R3: For a valid permutation, `done` is high for exactly one cycle. It rises after the 14th rising edge, counting the edge that accepted `start` as the first, and `busy` is low in that cycle.
- R4: If two entries of `funcIn` are equal, `done` and `notPerm` rise after the 2nd edge. `canonOut`, `permIdx` and `invFlag` are then zero.
- R5: Entry i of a vector sits at bits [3i+2:3i] of `funcIn` and of `canonOut`. On success, `canonOut` is the smallest of the twelve candidates in lexicographic order, where entry 0 is the most significant.
- R6: For a bit permutation p, with p[j] in 0..2, define P(x) so that bit j of P(x) equals bit p[j] of x. The candidate built from a source function s is g(x) = P(s(Q(x))), where Q is the inverse of P. The source s is either the function itself or its inverse.
- R7: `permIdx` numbers the permutations in lexicographic order of the tuple (p[0],p[1],p[2]): 0=(0,1,2), 1=(0,2,1), 2=(1,0,2), 3=(1,2,0), 4=(2,0,1), 5=(2,1,0). If several candidates tie for the minimum, the block reports the first one visited. The visit order is all six permutations without inversion, then all six with inversion.
- R8: `invFlag` is 1 exactly when the reported candidate was built from the inverse function.
- R9: `canonOut`, `permIdx`, `invFlag` and `notPerm` change only in a cycle in which `done` rises. Otherwise they hold their values.
- R10: The input [1,0,3,2,5,7,4,6] maps to itself with `permIdx`=0 and `invFlag`=0. The inputs [2,3,0,1,5,7,4,6] and [4,5,6,1,0,7,2,3] map to the same vector.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request; taken only while idle |
| funcIn | input | 24 | Function vector, entry i at bits [3i+2:3i] |
| busy | output | 1 | A request is in progress |
| done | output | 1 | One-cycle completion pulse |
| notPerm | output | 1 | The last request had duplicate entries |
| canonOut | output | 24 | Canonical vector, same layout as `funcIn` |
| permIdx | output | 3 | Index of the winning bit permutation |
| invFlag | output | 1 | The winner was built from the inverse |

## Verification
Tie-breaking is the hardest behaviour to reach. Several candidates must reach the same minimum, so that the result shows whether the first one in visit order was kept. Functions that are symmetric under bit renaming, and involutions whose inverse equals the function itself, force such ties by construction. The bench applies both kinds, alongside random permutations from shuffling. It also injects a second `start` in the middle of a run with a different vector, to show that the request is ignored.

// File: rtl/revCanonPkg.sv
package revCanonPkg;

  localparam int VARS = 3;
  localparam int ENTRIES = 1 << VARS;
  localparam int SELW = (VARS > 1) ? $clog2(VARS) : 1;

  function automatic int factorial(input int n);
    int acc;
    acc = 1;
    for (int i = 2; i <= n; i++) acc = acc * i;
    return acc;
  endfunction

  localparam int PERMS = factorial(VARS);
  localparam int CANDS = 2 * PERMS;
  localparam int IDXW = $clog2(CANDS);
  localparam int PIDXW = $clog2(PERMS);

  typedef logic [VARS-1:0] word_t;
  typedef logic [ENTRIES-1:0][VARS-1:0] vec_t;
  typedef logic [ENTRIES*VARS-1:0] key_t;
  typedef logic [VARS-1:0][SELW-1:0] perm_t;

  typedef struct packed {
    logic loadFunc;
    logic flagErr;
    logic evalCand;
    logic firstCand;
    logic publish;
  } strobe_t;

  // Decode a permutation index into its tuple (lexicographic order, Lehmer code)
  function automatic perm_t permOf(input int idx);
    int avail [VARS];
    int rem, f, d;
    perm_t p;
    p = '0;
    rem = idx;
    for (int i = 0; i < VARS; i++) avail[i] = i;
    for (int pos = 0; pos < VARS; pos++) begin
      f = factorial(VARS - 1 - pos);
      d = rem / f;
      rem = rem % f;
      if (d > VARS - 1 - pos) d = VARS - 1 - pos;
      p[pos] = SELW'(avail[d]);
      for (int k = 0; k < VARS - 1; k++)
        if (k >= d) avail[k] = avail[k+1];
    end
    return p;
  endfunction

  function automatic word_t applyPerm(input word_t x, input perm_t p);
    word_t y;
    for (int j = 0; j < VARS; j++) y[j] = x[p[j]];
    return y;
  endfunction

  function automatic word_t undoPerm(input word_t x, input perm_t p);
    word_t y;
    y = '0;
    for (int j = 0; j < VARS; j++) y[p[j]] = x[j];
    return y;
  endfunction

  // Entry 0 becomes the most significant slice
  function automatic key_t lexKey(input vec_t v);
    key_t k;
    for (int i = 0; i < ENTRIES; i++) k[(ENTRIES-1-i)*VARS +: VARS] = v[i];
    return k;
  endfunction

  function automatic logic isPermutation(input vec_t v);
    logic [ENTRIES-1:0] seen;
    seen = '0;
    for (int i = 0; i < ENTRIES; i++) seen[v[i]] = 1'b1;
    return &seen;
  endfunction

endpackage

// File: rtl/revCanonCtrl.sv
module revCanonCtrl
  import revCanonPkg::*;
(
  input  logic            clk,
  input  logic            rstN,
  input  logic            start,
  input  logic            permOk,
  output strobe_t         strobe,
  output logic [IDXW-1:0] candIdx,
  output logic            busy,
  output logic            done
);

  typedef enum logic [1:0] {ST_IDLE, ST_CHECK, ST_SCAN} state_t;

  state_t state;
  logic [IDXW-1:0] cnt;
  logic lastCand;

  assign lastCand = (cnt == IDXW'(CANDS - 1));
  assign candIdx = cnt;
  assign busy = (state != ST_IDLE);

  always_comb begin
    strobe = '0;
    strobe.loadFunc  = (state == ST_IDLE) && start;
    strobe.flagErr   = (state == ST_CHECK) && !permOk;
    strobe.evalCand  = (state == ST_SCAN);
    strobe.firstCand = (state == ST_SCAN) && (cnt == '0);
    strobe.publish   = (state == ST_SCAN) && lastCand;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
      cnt   <= '0;
      done  <= 1'b0;
    end else begin
      done <= strobe.flagErr || strobe.publish;
      unique case (state)
        ST_IDLE: begin
          cnt <= '0;
          if (start) state <= ST_CHECK;
        end
        ST_CHECK: begin
          cnt   <= '0;
          state <= permOk ? ST_SCAN : ST_IDLE;
        end
        ST_SCAN: begin
          cnt <= cnt + 1'b1;
          if (lastCand) state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done); // R3

  AST_START_TAKEN: assert property (@(posedge clk) disable iff (!rstN)
    (start && !busy) |=> busy); // R2

  AST_IDLE_AT_DONE: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy); // R3

  AST_CAND_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_SCAN) |-> (cnt < IDXW'(CANDS))); // R7

endmodule

// File: rtl/revCanonDp.sv
module revCanonDp
  import revCanonPkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  strobe_t          strobe,
  input  logic [IDXW-1:0]  candIdx,
  input  vec_t             funcIn,
  output logic             permOk,
  output vec_t             canonOut,
  output logic [PIDXW-1:0] permIdx,
  output logic             invFlag,
  output logic             notPerm
);

  vec_t funcReg;
  vec_t invVec;
  vec_t srcVec;
  vec_t candVec;
  vec_t bestVec;
  logic [PIDXW-1:0] bestPerm;
  logic bestInv;

  perm_t curPerm;
  logic [PIDXW-1:0] curPermIdx;
  logic curInv;
  logic takeCand;

  vec_t nextVec;
  logic [PIDXW-1:0] nextPerm;
  logic nextInv;

  assign permOk = isPermutation(funcReg);

  // Inverse: entry at index f(i) holds i
  always_comb begin
    invVec = '0;
    for (int i = 0; i < ENTRIES; i++) invVec[funcReg[i]] = word_t'(i);
  end

  assign curInv = (candIdx >= IDXW'(PERMS));
  assign curPermIdx = PIDXW'(int'(candIdx) % PERMS);
  assign curPerm = permOf(int'(curPermIdx));
  assign srcVec = curInv ? invVec : funcReg;

  // Conjugate the source by the selected bit permutation
  always_comb begin
    for (int x = 0; x < ENTRIES; x++)
      candVec[x] = applyPerm(srcVec[undoPerm(word_t'(x), curPerm)], curPerm);
  end

  // Strict compare keeps the earliest candidate on a tie
  assign takeCand = strobe.firstCand || (lexKey(candVec) < lexKey(bestVec));
  assign nextVec  = takeCand ? candVec : bestVec;
  assign nextPerm = takeCand ? curPermIdx : bestPerm;
  assign nextInv  = takeCand ? curInv : bestInv;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      funcReg  <= '0;
      bestVec  <= '0;
      bestPerm <= '0;
      bestInv  <= 1'b0;
      canonOut <= '0;
      permIdx  <= '0;
      invFlag  <= 1'b0;
      notPerm  <= 1'b0;
    end else begin
      if (strobe.loadFunc) funcReg <= funcIn;
      if (strobe.evalCand) begin
        bestVec  <= nextVec;
        bestPerm <= nextPerm;
        bestInv  <= nextInv;
      end
      if (strobe.publish) begin
        canonOut <= nextVec;
        permIdx  <= nextPerm;
        invFlag  <= nextInv;
        notPerm  <= 1'b0;
      end else if (strobe.flagErr) begin
        canonOut <= '0;
        permIdx  <= '0;
        invFlag  <= 1'b0;
        notPerm  <= 1'b1;
      end
    end
  end

  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !(strobe.publish || strobe.flagErr) |=>
      ($stable(canonOut) && $stable(permIdx) && $stable(invFlag) && $stable(notPerm))); // R9

  AST_ERR_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    strobe.flagErr |=> (notPerm && canonOut == '0 && permIdx == '0 && !invFlag)); // R4

  AST_RESULT_IS_PERM: assert property (@(posedge clk) disable iff (!rstN)
    strobe.publish |=> (isPermutation(canonOut) && !notPerm)); // R5

  AST_BEST_NONINCREASING: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.evalCand && !strobe.firstCand) |=>
      (lexKey(bestVec) <= $past(lexKey(bestVec)))); // R5

  AST_PERM_IDX_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    strobe.publish |=> (permIdx < PIDXW'(PERMS))); // R7

endmodule

// File: rtl/revCanon.sv
module revCanon
  import revCanonPkg::*;
(
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      start,
  input  logic [ENTRIES*VARS-1:0]   funcIn,
  output logic                      busy,
  output logic                      done,
  output logic                      notPerm,
  output logic [ENTRIES*VARS-1:0]   canonOut,
  output logic [PIDXW-1:0]          permIdx,
  output logic                      invFlag
);

  strobe_t strobe;
  logic [IDXW-1:0] candIdx;
  logic permOk;
  vec_t canonVec;

  revCanonCtrl uCtrl (
    .clk     (clk),
    .rstN    (rstN),
    .start   (start),
    .permOk  (permOk),
    .strobe  (strobe),
    .candIdx (candIdx),
    .busy    (busy),
    .done    (done)
  );

  revCanonDp uDp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .candIdx  (candIdx),
    .funcIn   (vec_t'(funcIn)),
    .permOk   (permOk),
    .canonOut (canonVec),
    .permIdx  (permIdx),
    .invFlag  (invFlag),
    .notPerm  (notPerm)
  );

  assign canonOut = canonVec;

endmodule

// File: tb/tb_revCanon.sv
`timescale 1ns/1ps
module tb_revCanon;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0;
  logic [23:0] funcIn = '0;
  logic busy, done, notPerm, invFlag;
  logic [23:0] canonOut;
  logic [2:0] permIdx;

  int nCmp = 0;
  int nBad = 0;
  int permTab [6][3];

  always #10 clk = ~clk;

  revCanon dut (
    .clk(clk), .rstN(rstN), .start(start), .funcIn(funcIn),
    .busy(busy), .done(done), .notPerm(notPerm),
    .canonOut(canonOut), .permIdx(permIdx), .invFlag(invFlag)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    nCmp++;
    if (!ok) begin
      nBad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  endtask

  initial begin
    #(20ns * 200000);
    nBad++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  function automatic int pBits(input int x, input int pi);
    int y = 0;
    for (int j = 0; j < 3; j++) if ((x >> permTab[pi][j]) & 1) y |= (1 << j);
    return y;
  endfunction

  function automatic int qBits(input int x, input int pi);
    int y = 0;
    for (int j = 0; j < 3; j++) if ((x >> j) & 1) y |= (1 << permTab[pi][j]);
    return y;
  endfunction

  function automatic logic [23:0] pack(input int v [8]);
    logic [23:0] r = '0;
    for (int i = 0; i < 8; i++) r[i*3 +: 3] = v[i][2:0];
    return r;
  endfunction

  // Behavioural reference: enumerate the class and keep the first minimum
  task automatic model(input int f [8], output int best [8], output int bp,
                       output int bi, output bit ok);
    int seen [8];
    int fi [8];
    int cand [8];
    bit first;
    foreach (seen[i]) seen[i] = 0;
    foreach (f[i]) seen[f[i]]++;
    ok = 1;
    foreach (seen[i]) if (seen[i] != 1) ok = 0;
    bp = 0; bi = 0;
    foreach (best[i]) best[i] = 0;
    if (!ok) return;
    foreach (f[i]) fi[f[i]] = i;
    first = 1;
    for (int inv = 0; inv < 2; inv++)
      for (int pi = 0; pi < 6; pi++) begin
        bit less;
        bit decided;
        for (int x = 0; x < 8; x++) begin
          int s = qBits(x, pi);
          cand[x] = pBits(inv ? fi[s] : f[s], pi);
        end
        less = 0; decided = 0;
        for (int i = 0; i < 8; i++)
          if (!decided && cand[i] != best[i]) begin
            decided = 1;
            less = cand[i] < best[i];
          end
        if (first || less) begin
          best = cand; bp = pi; bi = inv; first = 0;
        end
      end
  endtask

  // Runs one request and compares busy/done every cycle, then the result
  task automatic runCase(input int f [8], input bit poke, input string tag);
    int best [8];
    int bp, bi, lat;
    bit ok;
    logic [23:0] expVec;
    int other [8];
    model(f, best, bp, bi, ok);
    expVec = pack(best);
    lat = ok ? 14 : 2;
    @(negedge clk);
    funcIn = pack(f);
    start = 1'b1;
    for (int k = 1; k <= lat; k++) begin
      @(posedge clk);
      @(negedge clk);
      start = 1'b0;
      if (poke && k == 4) begin
        // R2: second request while busy must be ignored
        foreach (other[i]) other[i] = (i + 3) % 8;
        funcIn = pack(other);
        start = 1'b1;
      end
      check(busy == (k < lat), $sformatf("R2 busy %s k=%0d", tag, k), busy, k < lat);
      check(done == (k == lat), $sformatf("R3 done %s k=%0d", tag, k), done, k == lat);
    end
    start = 1'b0;
    check(notPerm == !ok, {"R4 notPerm ", tag}, notPerm, !ok);
    check(canonOut == expVec, {"R5 R6 canon ", tag}, canonOut, expVec);
    check(permIdx == bp[2:0], {"R7 permIdx ", tag}, permIdx, bp);
    check(invFlag == bi[0], {"R8 invFlag ", tag}, invFlag, bi);
    @(posedge clk);
    @(negedge clk);
    check(!done, {"R3 pulse width ", tag}, done, 0);
    check(canonOut == expVec && permIdx == bp[2:0] && invFlag == bi[0],
          {"R9 hold ", tag}, canonOut, expVec);
  endtask

  initial begin
    int f [8];
    int n = 0;
    for (int a = 0; a < 3; a++)
      for (int b = 0; b < 3; b++)
        for (int c = 0; c < 3; c++)
          if (a != b && b != c && a != c) begin
            permTab[n][0] = a; permTab[n][1] = b; permTab[n][2] = c; n++;
          end

    repeat (3) @(posedge clk);
    @(negedge clk);
    check(!busy && !done && !notPerm, "R1 flags after reset", {busy, done, notPerm}, 0);
    check(canonOut == '0 && permIdx == '0 && !invFlag, "R1 data after reset", canonOut, 0);
    rstN = 1'b1;

    // R10: the stated example and two members of its class
    f = '{1,0,3,2,5,7,4,6};
    runCase(f, 0, "R10 example");
    check(canonOut == pack(f) && permIdx == 0 && !invFlag, "R10 self-canonical", canonOut, pack(f));
    f = '{2,3,0,1,5,7,4,6};
    runCase(f, 0, "R10 member a");
    check(canonOut == pack('{1,0,3,2,5,7,4,6}), "R10 member a", canonOut, pack('{1,0,3,2,5,7,4,6}));
    f = '{4,5,6,1,0,7,2,3};
    runCase(f, 0, "R10 member b");

    // R7 ties: identity and a fully symmetric involution
    f = '{0,1,2,3,4,5,6,7};
    runCase(f, 0, "R7 identity");
    f = '{7,6,5,4,3,2,1,0};
    runCase(f, 0, "R7 complement");
    f = '{0,2,1,3,4,6,5,7};
    runCase(f, 0, "R7 swap involution");

    // R4: duplicate entries
    f = '{0,1,2,3,4,5,6,6};
    runCase(f, 0, "R4 dup");
    f = '{3,3,3,3,3,3,3,3};
    runCase(f, 0, "R4 const");

    // R2: start during a run is ignored
    f = '{5,1,7,0,2,6,3,4};
    runCase(f, 1, "R2 poke");

    // R5 R6 R8: random permutations
    for (int t = 0; t < 20; t++) begin
      for (int i = 0; i < 8; i++) f[i] = i;
      for (int i = 7; i > 0; i--) begin
        int j = $urandom_range(i, 0);
        int tmp = f[i]; f[i] = f[j]; f[j] = tmp;
      end
      runCase(f, 0, $sformatf("R5 random %0d", t));
    end

    finishRun();
  end

endmodule